// File: doc/BRIEF.md
# Extended-Precision Compare and Classify Unit

This combinational unit works on 80-bit extended-precision operands. In that format bit 79 is the sign, bits 78:64 hold a 15-bit biased exponent, and bits 63:0 hold the significand. The integer bit (bit 63) is stored in the word rather than implied.

The compare path orders the top operand `op_a` against a second operand `op_b`. When `cmp_zero` is set, it orders `op_a` against zero instead. The result is a condition code in C3/C2/C0 form. The path also raises an invalid-operation flag and a denormal-operand flag. An unordered variant, selected by `unord_mode`, reports quiet NaNs without raising invalid-operation.

The classify path looks at `op_a` alone and reports its class in C3/C2/C1/C0 form. An empty-register input overrides the class.

The unit is meant to sit beside a register stack. The stack supplies the operands and the empty tag, and it stores the condition codes and flags itself.

Top module: `fpx_cmp_class`

## Requirements
- R1: `cmp_cc` is {C3,C2,C1,C0}. For ordered operands, a greater `op_a` gives 4'b0000, a smaller one gives 4'b0001, and an equal one gives 4'b1000.
- R2: Operands are ordered by numeric value, not by bit pattern. A denormal (exponent 0) weighs as exponent 1. An unnormal equals the normal of the same value. +0 and -0 are equal.
- R3: With `cmp_zero`=1, `op_a` is ordered against zero using the R1 codes, and `op_b` has no effect on any output.
- R4: If any compared operand is a NaN, `cmp_cc` is 4'b1101 (unordered).
- R5: C1 of `cmp_cc` (bit 1) is always 0.
- R6: With `unord_mode`=0, `cmp_invalid` is 1 exactly when a compared operand is a NaN.
- R7: With `unord_mode`=1, `cmp_invalid` is 1 exactly when a compared operand is a signaling NaN. A signaling NaN is a NaN whose bit 62 is 0.
- R8: `cmp_denorm` is 1 exactly when a compared operand has exponent 0 and a nonzero significand.
- R9: `cls_cc` gives {C3,C2,C0} by class: unnormal 000, normal 010, zero 100, denormal 110, NaN 001, infinity 011. An unnormal has a nonzero, non-maximal exponent and bit 63 clear.
- R10: C1 of `cls_cc` (bit 1) equals the sign bit of `op_a`.
- R11: With `a_empty`=1, `cls_cc` has C3=1 and C0=1 whatever `op_a` holds.
- R12: A maximal exponent (all ones) marks infinity when bits 62:0 are zero, and a NaN otherwise. Bit 63 does not take part in that decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 80 | Top operand: compared, and classified |
| op_b | input | 80 | Second operand for the compare |
| cmp_zero | input | 1 | Compare `op_a` against zero |
| unord_mode | input | 1 | Unordered compare: quiet NaNs do not raise invalid |
| a_empty | input | 1 | The register holding `op_a` is empty |
| cmp_cc | output | 4 | Compare condition code {C3,C2,C1,C0} |
| cmp_invalid | output | 1 | Invalid-operation flag from the compare |
| cmp_denorm | output | 1 | Denormal-operand flag from the compare |
| cls_cc | output | 4 | Class condition code {C3,C2,C1,C0} |

## Verification
The hardest cases to reach are equal values held in different encodings. Examples are an unnormal against the normal of the same value, and a pseudo-denormal against the smallest normal. Both need the normalizing path to line the operands up exactly. A signaling NaN whose only payload bit lies below bit 62 is also hard to reach.

The stimulus sweeps every ordered pair from a hand-picked operand set that contains these encodings, in all four combinations of `cmp_zero` and `unord_mode`. The bench computes the expected order with its own shift-and-decrement normalization.

// File: rtl/fpx_pkg.sv
`timescale 1ns/1ps
package fpx_pkg;
  localparam int EXP_W     = 15;
  localparam int MAN_W     = 64;
  localparam int WORD_W    = 1 + EXP_W + MAN_W;
  localparam int LZ_W      = $clog2(MAN_W) + 1;
  localparam int KEY_EXP_W = EXP_W + 2;
  localparam int KEY_W     = KEY_EXP_W + MAN_W;
  localparam int QUIET_BIT = MAN_W - 2;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [MAN_W-1:0] man;
  } fpx_word_t;

  typedef enum logic [2:0] {
    CL_UNNORM, CL_NORM, CL_ZERO, CL_DENORM, CL_NAN, CL_INF
  } fpx_class_e;

  typedef enum logic [1:0] {ORD_GT, ORD_LT, ORD_EQ} fpx_ord_e;

  // Number of leading zero bits; MAN_W for an all-zero significand.
  function automatic logic [LZ_W-1:0] lead_zeros(input logic [MAN_W-1:0] m);
    logic [LZ_W-1:0] n;
    logic            found;
    n = LZ_W'(MAN_W);
    found = 1'b0;
    for (int i = MAN_W - 1; i >= 0; i--) begin
      if (!found && m[i]) begin
        n = LZ_W'(MAN_W - 1 - i);
        found = 1'b1;
      end
    end
    return n;
  endfunction

  // Magnitude key: {normalised exponent, normalised significand}.
  // Zero magnitude maps to 0, infinity to all ones.
  function automatic logic [KEY_W-1:0] mag_key(input fpx_word_t w, input fpx_class_e c);
    logic [EXP_W-1:0]     e_eff;
    logic [LZ_W-1:0]      lz;
    logic [KEY_EXP_W-1:0] ke;
    logic [MAN_W-1:0]     nm;
    if (c == CL_INF) return '1;
    if (w.man == '0) return '0;
    e_eff = (w.exp == '0) ? EXP_W'(1) : w.exp;
    lz    = lead_zeros(w.man);
    ke    = KEY_EXP_W'(e_eff) + KEY_EXP_W'(MAN_W) - KEY_EXP_W'(lz);
    nm    = w.man << lz;
    return {ke, nm};
  endfunction

  // Class to {C3,C2,C0}.
  function automatic logic [2:0] class_code(input fpx_class_e c);
    case (c)
      CL_UNNORM: return 3'b000;
      CL_NORM:   return 3'b010;
      CL_ZERO:   return 3'b100;
      CL_DENORM: return 3'b110;
      CL_NAN:    return 3'b001;
      default:   return 3'b011;
    endcase
  endfunction
endpackage

// File: rtl/fpx_classify.sv
`timescale 1ns/1ps
module fpx_classify
  import fpx_pkg::*;
(
  input  fpx_word_t  w,
  output fpx_class_e cls,
  output logic       snan
);
  logic exp_max, exp_min, low_zero;

  always_comb begin
    exp_max  = (w.exp == '1);
    exp_min  = (w.exp == '0);
    low_zero = (w.man[MAN_W-2:0] == '0);
    if (exp_max)                cls = low_zero ? CL_INF : CL_NAN;
    else if (exp_min)           cls = (w.man == '0) ? CL_ZERO : CL_DENORM;
    else if (!w.man[MAN_W-1])   cls = CL_UNNORM;
    else                        cls = CL_NORM;
    snan = exp_max && !low_zero && !w.man[QUIET_BIT];
  end
endmodule

// File: rtl/fpx_order.sv
`timescale 1ns/1ps
module fpx_order
  import fpx_pkg::*;
(
  input  fpx_word_t  a,
  input  fpx_word_t  b,
  input  fpx_class_e a_cls,
  input  fpx_class_e b_cls,
  output fpx_ord_e   ord
);
  logic [KEY_W-1:0] ka, kb;
  logic za, zb, sa, sb, mag_gt;

  always_comb begin
    ka     = mag_key(a, a_cls);
    kb     = mag_key(b, b_cls);
    za     = (ka == '0);
    zb     = (kb == '0);
    sa     = a.sign && !za;
    sb     = b.sign && !zb;
    mag_gt = (ka > kb);
    if (za && zb)        ord = ORD_EQ;
    else if (sa != sb)   ord = sa ? ORD_LT : ORD_GT;
    else if (ka == kb)   ord = ORD_EQ;
    else                 ord = (mag_gt ^ sa) ? ORD_GT : ORD_LT;
  end
endmodule

// File: rtl/fpx_cmp_class.sv
`timescale 1ns/1ps
module fpx_cmp_class
  import fpx_pkg::*;
(
  input  logic [79:0] op_a,
  input  logic [79:0] op_b,
  input  logic        cmp_zero,
  input  logic        unord_mode,
  input  logic        a_empty,
  output logic [3:0]  cmp_cc,
  output logic        cmp_invalid,
  output logic        cmp_denorm,
  output logic [3:0]  cls_cc
);
  localparam int N_OPS = 2;

  fpx_word_t  opw  [N_OPS];
  fpx_class_e ocls [N_OPS];
  logic       osnan[N_OPS];
  fpx_ord_e   ord;

  // Named events for the checker
  logic a_nan, b_nan, a_snan, b_snan, a_is_zero, unordered;
  logic [2:0] a_code;

  assign opw[0] = fpx_word_t'(op_a);
  assign opw[1] = cmp_zero ? fpx_word_t'('0) : fpx_word_t'(op_b);

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    fpx_classify u_cls (.w(opw[g]), .cls(ocls[g]), .snan(osnan[g]));
  end

  fpx_order u_ord (
    .a(opw[0]), .b(opw[1]), .a_cls(ocls[0]), .b_cls(ocls[1]), .ord(ord)
  );

  assign a_nan     = (ocls[0] == CL_NAN);
  assign b_nan     = (ocls[1] == CL_NAN);
  assign a_snan    = osnan[0];
  assign b_snan    = osnan[1];
  assign a_is_zero = (ocls[0] == CL_ZERO);
  assign unordered = a_nan || b_nan;
  assign a_code    = class_code(ocls[0]);

  always_comb begin
    if (unordered)            cmp_cc = 4'b1101;
    else if (ord == ORD_GT)   cmp_cc = 4'b0000;
    else if (ord == ORD_LT)   cmp_cc = 4'b0001;
    else                      cmp_cc = 4'b1000;
    cmp_invalid = unord_mode ? (a_snan || b_snan) : unordered;
    cmp_denorm  = (ocls[0] == CL_DENORM) || (ocls[1] == CL_DENORM);
    if (a_empty) cls_cc = {1'b1, 1'b0, op_a[79], 1'b1};
    else         cls_cc = {a_code[2], a_code[1], op_a[79], a_code[0]};
  end
endmodule

// File: rtl/fpx_cmp_class_chk.sv
`timescale 1ns/1ps
module fpx_cmp_class_chk (
  input logic       sign_a,
  input logic       cmp_zero,
  input logic       unord_mode,
  input logic       a_empty,
  input logic [3:0] cmp_cc,
  input logic [3:0] cls_cc,
  input logic       cmp_invalid,
  input logic       a_nan,
  input logic       b_nan,
  input logic       a_snan,
  input logic       b_snan,
  input logic       a_is_zero
);
  always_comb begin
    // R5
    cmp_c1_clear_chk: assert (cmp_cc[1] == 1'b0);
    // R4
    nan_unordered_chk: assert ((a_nan || b_nan) == (cmp_cc == 4'b1101));
    // R6
    ordered_invalid_chk: assert (unord_mode || ((a_nan || b_nan) == cmp_invalid));
    // R7
    quiet_no_invalid_chk: assert (!unord_mode || (cmp_invalid == (a_snan || b_snan)));
    // R11
    empty_code_chk: assert (!a_empty || (cls_cc[3] && cls_cc[0]));
    // R10
    class_sign_chk: assert (cls_cc[1] == sign_a);
    // R3
    zero_vs_zero_chk: assert (!(cmp_zero && a_is_zero) || (cmp_cc == 4'b1000));
  end
endmodule

bind fpx_cmp_class fpx_cmp_class_chk u_chk (
  .sign_a(op_a[79]), .cmp_zero(cmp_zero), .unord_mode(unord_mode),
  .a_empty(a_empty), .cmp_cc(cmp_cc), .cls_cc(cls_cc),
  .cmp_invalid(cmp_invalid), .a_nan(a_nan), .b_nan(b_nan),
  .a_snan(a_snan), .b_snan(b_snan), .a_is_zero(a_is_zero)
);

// File: tb/tb_fpx_cmp_class.sv
`timescale 1ns/1ps
module tb_fpx_cmp_class;
  localparam int NOPS = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [79:0] op_a = '0, op_b = '0;
  logic        cmp_zero = 1'b0, unord_mode = 1'b0, a_empty = 1'b0;
  logic [3:0]  cmp_cc, cls_cc;
  logic        cmp_invalid, cmp_denorm;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  fpx_cmp_class dut (
    .op_a(op_a), .op_b(op_b), .cmp_zero(cmp_zero), .unord_mode(unord_mode),
    .a_empty(a_empty), .cmp_cc(cmp_cc), .cmp_invalid(cmp_invalid),
    .cmp_denorm(cmp_denorm), .cls_cc(cls_cc)
  );

  function automatic logic [79:0] op_at(input int i);
    case (i)
      0:  return {1'b0, 15'h0000, 64'h0};
      1:  return {1'b1, 15'h0000, 64'h0};
      2:  return {1'b0, 15'h3fff, 64'h8000000000000000};
      3:  return {1'b1, 15'h3fff, 64'h8000000000000000};
      4:  return {1'b0, 15'h4000, 64'h8000000000000000};
      5:  return {1'b0, 15'h3fff, 64'hC000000000000000};
      6:  return {1'b0, 15'h4000, 64'h4000000000000000};
      7:  return {1'b1, 15'h4001, 64'h2000000000000000};
      8:  return {1'b0, 15'h0000, 64'h0000000000000001};
      9:  return {1'b0, 15'h0000, 64'h4000000000000000};
      10: return {1'b1, 15'h0000, 64'h4000000000000000};
      11: return {1'b0, 15'h0001, 64'h8000000000000000};
      12: return {1'b0, 15'h7ffe, 64'hFFFFFFFFFFFFFFFF};
      13: return {1'b0, 15'h7fff, 64'h8000000000000000};
      14: return {1'b1, 15'h7fff, 64'h8000000000000000};
      15: return {1'b0, 15'h7fff, 64'hC000000000000000};
      16: return {1'b1, 15'h7fff, 64'hC000000000000001};
      17: return {1'b0, 15'h7fff, 64'h8000000000000001};
      18: return {1'b1, 15'h7fff, 64'hA000000000000000};
      default: return {1'b0, 15'h0000, 64'h8000000000000000};
    endcase
  endfunction

  function automatic bit is_nan(input logic [79:0] x);
    return (x[78:64] == 15'h7fff) && (x[62:0] != 63'h0);
  endfunction
  function automatic bit is_inf(input logic [79:0] x);
    return (x[78:64] == 15'h7fff) && (x[62:0] == 63'h0);
  endfunction
  function automatic bit is_den(input logic [79:0] x);
    return (x[78:64] == 15'h0) && (x[63:0] != 64'h0);
  endfunction
  function automatic bit is_snan(input logic [79:0] x);
    return is_nan(x) && !x[62];
  endfunction

  // {C3,C2,C0}
  function automatic logic [2:0] exp_class(input logic [79:0] x);
    if (is_nan(x)) return 3'b001;
    if (is_inf(x)) return 3'b011;
    if (x[78:64] == 15'h0) return (x[63:0] == 64'h0) ? 3'b100 : 3'b110;
    return x[63] ? 3'b010 : 3'b000;
  endfunction

  // Returns 1 if |a|>|b|, -1 if smaller, 0 if equal (non-NaN inputs)
  function automatic int mag_cmp(input logic [79:0] a, input logic [79:0] b);
    int ea, eb;
    logic [63:0] ma, mb;
    if (is_inf(a) && is_inf(b)) return 0;
    if (is_inf(a)) return 1;
    if (is_inf(b)) return -1;
    ma = a[63:0]; mb = b[63:0];
    if (ma == 0 && mb == 0) return 0;
    if (ma == 0) return -1;
    if (mb == 0) return 1;
    ea = (a[78:64] == 0) ? 1 : int'(a[78:64]);
    eb = (b[78:64] == 0) ? 1 : int'(b[78:64]);
    while (!ma[63]) begin ma = ma << 1; ea = ea - 1; end
    while (!mb[63]) begin mb = mb << 1; eb = eb - 1; end
    if (ea != eb) return (ea > eb) ? 1 : -1;
    if (ma != mb) return (ma > mb) ? 1 : -1;
    return 0;
  endfunction

  function automatic logic [3:0] exp_cmp(input logic [79:0] a, input logic [79:0] b);
    int m;
    bit za, zb, sa, sb;
    if (is_nan(a) || is_nan(b)) return 4'b1101;
    za = !is_inf(a) && a[63:0] == 0;
    zb = !is_inf(b) && b[63:0] == 0;
    sa = a[79] && !za;
    sb = b[79] && !zb;
    if (sa != sb) return sa ? 4'b0001 : 4'b0000;
    m = mag_cmp(a, b);
    if (m == 0) return 4'b1000;
    if (sa) m = -m;
    return (m > 0) ? 4'b0000 : 4'b0001;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h z=%0b u=%0b e=%0b)",
               req, act, exp, op_a, op_b, cmp_zero, unord_mode, a_empty);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [79:0] a, b, bz;
    logic [3:0]  ec;
    logic [2:0]  cc;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Idle state: +0 vs +0, classify +0
    check("R1", {4'h0, cmp_cc}, 8'h08);
    check("R9", {4'h0, cls_cc}, 8'h08);
    check("R8", {7'h0, cmp_denorm}, 8'h00);

    for (int i = 0; i < NOPS; i++) begin
      for (int j = 0; j < NOPS; j++) begin
        for (int z = 0; z < 2; z++) begin
          for (int u = 0; u < 2; u++) begin
            a = op_at(i); b = op_at(j);
            @(negedge clk);
            op_a = a; op_b = b; cmp_zero = z[0]; unord_mode = u[0]; a_empty = 1'b0;
            @(posedge clk); #1;
            bz = z[0] ? 80'h0 : b;
            ec = exp_cmp(a, bz);
            // R1 R2 R3 R4 R5: code of a vs b (or zero)
            check(z[0] ? "R3" : (ec == 4'b1101 ? "R4" : "R2"), {4'h0, cmp_cc}, {4'h0, ec});
            check("R5", {7'h0, cmp_cc[1]}, 8'h00);
            if (u[0]) check("R7", {7'h0, cmp_invalid}, {7'h0, is_snan(a) || is_snan(bz)});
            else      check("R6", {7'h0, cmp_invalid}, {7'h0, is_nan(a) || is_nan(bz)});
            check("R8", {7'h0, cmp_denorm}, {7'h0, is_den(a) || is_den(bz)});
          end
        end
      end
      // Classification of op_a, with and without the empty tag
      a = op_at(i);
      @(negedge clk);
      op_a = a; a_empty = 1'b0;
      @(posedge clk); #1;
      cc = exp_class(a);
      check((a[78:64] == 15'h7fff) ? "R12" : "R9", {5'h0, cls_cc[3], cls_cc[2], cls_cc[0]}, {5'h0, cc});
      check("R10", {7'h0, cls_cc[1]}, {7'h0, a[79]});
      @(negedge clk);
      a_empty = 1'b1;
      @(posedge clk); #1;
      check("R11", {6'h0, cls_cc[3], cls_cc[0]}, 8'h03);
    end
    // Explicit R1 corner: 2.0 above 1.0, 1.0 below 2.0
    @(negedge clk);
    op_a = op_at(4); op_b = op_at(2); cmp_zero = 1'b0; unord_mode = 1'b0; a_empty = 1'b0;
    @(posedge clk); #1;
    check("R1", {4'h0, cmp_cc}, 8'h00);
    @(negedge clk);
    op_a = op_at(2); op_b = op_at(4);
    @(posedge clk); #1;
    check("R1", {4'h0, cmp_cc}, 8'h01);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule